// File: doc/BRIEF.md
# Vertical Sync Extractor

This block watches a composite sync signal that has already been sliced to one bit and sampled on a fixed system clock. The signal is active low. The block emits one active-low vertical sync pulse at the start of each vertical interval. It measures every low stretch of the input in clock cycles:

- A stretch shorter than a threshold is a horizontal or equalizing pulse, and the block ignores it.
- A stretch at or above the threshold is a broad serration pulse.

The output fires on the rising edge that ends the first broad pulse. Some nonstandard inputs never show serrations and just stay low. For these, a timeout measured from the falling edge forces the pulse out. After the block fires, it holds the output low for a set width. It then stays deaf for a lockout period, so the remaining serrations of the same field cannot trigger it again.

Timing parameters are given in nanoseconds together with the clock rate in MHz, and the block converts them to cycle counts. The defaults assume a 10 MHz clock and give these counts:

| Parameter | Cycles |
|---|---|
| Broad threshold | 159 |
| Timeout | 600 |
| Pulse width | 300 |
| Lockout | 4000 |

Top module: `vsync_extract`

## Requirements
- R1: While reset is asserted, and after it is released until a trigger occurs, `vsync_n` is 1 (inactive).
- R2: A low stretch of L consecutive low samples counts as broad only when L >= 159 cycles (default). A stretch of 158 cycles does not fire. A stretch of 159 cycles fires.
- R3: When the input is first sampled high at clock edge E after a broad stretch, `vsync_n` goes to 0 at edge E+1.
- R4: If the input is sampled low on 600 consecutive edges (default), `vsync_n` goes to 0 at the 600th edge after the first low sample, without waiting for a rising edge.
- R5: Each output pulse stays at 0 for exactly 300 cycles (default) before it returns to 1.
- R6: After `vsync_n` returns to 1, triggers are ignored for 4000 cycles (default). A trigger seen on the cycle after the lockout ends fires. A trigger one cycle earlier does not fire.
- R7: Narrow pulses (equalizing pulses of 23 cycles and horizontal pulses of 47 cycles) never produce an output pulse.
- R8: Asserting reset during an output pulse drives `vsync_n` to 1 at once and clears the lockout, so the next broad pulse after release fires normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (sampling clock for the sync input) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| csync_n | input | 1 | Sliced composite sync, active low |
| vsync_n | output | 1 | Vertical sync pulse, active low |

## Verification
Some properties are checked on every cycle by assertions:

- Every output fall is preceded by a trigger.
- Every pulse lasts exactly the set width.
- No fall occurs before the lockout gap has elapsed.
- The timeout strobe never lasts two cycles.
- The low-run counter is clear whenever the input has stayed high.
- The output stays idle under reset.

Other behaviour can only be shown by the bench's scenarios:

- The exact firing cycle relative to an input edge.
- The classification boundary at 158 and 159 cycles.
- The forced firing of a field with no serrations.
- The one-cycle edges of the lockout window.
- Recovery from a reset taken during a pulse.

// File: rtl/vsx_pkg.sv
package vsx_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_HOLD  = 2'd1,
    ST_LOCK  = 2'd2
  } fire_st_e;

  // Convert a duration in nanoseconds to whole clock cycles.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned mhz);
    return (ns * mhz) / 1000;
  endfunction

endpackage

// File: rtl/vsx_rst_sync.sv
module vsx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/vsx_run_meter.sv
module vsx_run_meter #(
  parameter int unsigned BROAD_CYC = 159,
  parameter int unsigned TMO_CYC   = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  output logic rise_broad,
  output logic tmo_hit
);

  localparam int unsigned RUN_W = $clog2(TMO_CYC + 1);
  localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(TMO_CYC);
  localparam logic [RUN_W-1:0] BROAD_V   = RUN_W'(BROAD_CYC);
  localparam logic [RUN_W-1:0] TMO_LAST  = RUN_W'(TMO_CYC - 1);

  logic             in_q, in_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             run_en;

  // Next-state: count consecutive low samples, saturating at the timeout.
  always_comb begin
    in_d   = csync_n;
    run_en = !in_q && (run_q != RUN_MAX);
    run_d  = run_q;
    if (in_q)        run_d = '0;
    else if (run_en) run_d = run_q + RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= 1'b1;
      run_q <= '0;
    end else begin
      in_q  <= in_d;
      run_q <= run_d;
    end
  end

  // First high sample after a long enough low stretch.
  assign rise_broad = in_q && (run_q >= BROAD_V);
  // Last cycle before the low stretch reaches the timeout length.
  assign tmo_hit    = !in_q && (run_q == TMO_LAST);

  AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_q && $past(in_q)) |-> (run_q == '0)) else $error("run counter kept value while input high"); // R2

  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> !tmo_hit) else $error("timeout strobe lasted two cycles"); // R4

endmodule

// File: rtl/vsx_fire_ctrl.sv
module vsx_fire_ctrl
  import vsx_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 300,
  parameter int unsigned LOCK_CYC  = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic vsync_n
);

  localparam int unsigned CNT_MAX = (PULSE_CYC > LOCK_CYC) ? PULSE_CYC : LOCK_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LD  = CNT_W'(LOCK_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_V  = CNT_W'(PULSE_CYC);
  localparam logic [CNT_W-1:0] LOCK_V   = CNT_W'(LOCK_CYC);
  localparam logic [CNT_W-1:0] SAT_V    = CNT_W'(CNT_MAX);

  fire_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             vs_q, vs_d;
  logic             cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    vs_d   = vs_q;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_ARMED: if (trig) begin
        st_d  = ST_HOLD;
        cnt_d = PULSE_LD;
        vs_d  = 1'b0;
      end
      ST_HOLD: if (cnt_q == '0) begin
        st_d  = ST_LOCK;
        cnt_d = LOCK_LD;
        vs_d  = 1'b1;
      end else begin
        cnt_en = 1'b1;
      end
      ST_LOCK: if (cnt_q == '0) st_d = ST_ARMED;
               else             cnt_en = 1'b1;
      default: begin
        st_d = ST_ARMED;
        vs_d = 1'b1;
      end
    endcase
    if (cnt_en) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ARMED;
      cnt_q <= '0;
      vs_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      vs_q  <= vs_d;
    end
  end

  assign vsync_n = vs_q;

  // Checker state: length of the current low pulse and of the high gap.
  logic [CNT_W-1:0] low_len, gap_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len <= '0;
      gap_len <= LOCK_V;
    end else begin
      low_len <= vsync_n ? '0 : ((low_len == SAT_V) ? low_len : low_len + CNT_W'(1));
      gap_len <= !vsync_n ? '0 : ((gap_len >= LOCK_V) ? gap_len : gap_len + CNT_W'(1));
    end
  end

  AST_FIRE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> $past(trig)) else $error("output fell without a trigger"); // R3

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> (low_len == PULSE_V)) else $error("pulse width wrong"); // R5

  AST_LOCK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> (gap_len >= LOCK_V)) else $error("fired inside lockout"); // R6

endmodule

// File: rtl/vsync_extract.sv
module vsync_extract
  import vsx_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 10,
  parameter int unsigned BROAD_NS   = 15_900,
  parameter int unsigned TIMEOUT_NS = 60_000,
  parameter int unsigned PULSE_NS   = 30_000,
  parameter int unsigned LOCKOUT_NS = 400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  output logic vsync_n
);

  localparam int unsigned BROAD_CYC = ns_to_cycles(BROAD_NS,   CLK_MHZ);
  localparam int unsigned TMO_CYC   = ns_to_cycles(TIMEOUT_NS, CLK_MHZ);
  localparam int unsigned PULSE_CYC = ns_to_cycles(PULSE_NS,   CLK_MHZ);
  localparam int unsigned LOCK_CYC  = ns_to_cycles(LOCKOUT_NS, CLK_MHZ);

  logic rst_sync_n;
  logic rise_broad, tmo_hit, trig;

  vsx_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  vsx_run_meter #(.BROAD_CYC(BROAD_CYC), .TMO_CYC(TMO_CYC)) u_meter (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .csync_n    (csync_n),
    .rise_broad (rise_broad),
    .tmo_hit    (tmo_hit)
  );

  assign trig = rise_broad | tmo_hit;

  vsx_fire_ctrl #(.PULSE_CYC(PULSE_CYC), .LOCK_CYC(LOCK_CYC)) u_fire (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .trig    (trig),
    .vsync_n (vsync_n)
  );

  always @(negedge clk) begin
    if (!rst_sync_n) begin
      AST_RST_IDLE: assert (vsync_n) else $error("output active during reset"); // R1
    end
  end

endmodule

// File: tb/sim_vsync_extract.sv
module sim_vsync_extract;

  localparam int CLK_NS = 100;
  localparam int BROAD  = 159;
  localparam int TMO    = 600;
  localparam int PW     = 300;
  localparam int LOCK   = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync_n = 1'b1;
  logic vsync_n;

  always #(CLK_NS/2) clk = ~clk;

  vsync_extract u0 (.clk(clk), .rst_n(rst_n), .csync_n(csync_n), .vsync_n(vsync_n));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_chk = 0, n_err = 0, n_fall = 0, fall_cyc = 0;
  int    exp_q[$];
  string tag_q[$];
  string cur_req = "R1";
  bit    no_width = 1'b0;
  logic  vs_prev = 1'b1;
  int    e_cyc;
  string e_tag;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // Scoreboard monitor: compares each output fall against the expected queue.
  always @(negedge clk) begin
    if (vs_prev === 1'b1 && vsync_n === 1'b0) begin
      n_fall++;
      fall_cyc = cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, cyc, -1);
      end else begin
        e_cyc = exp_q.pop_front();
        e_tag = tag_q.pop_front();
        check(cyc == e_cyc, e_tag, cyc, e_cyc);
      end
    end
    if (vs_prev === 1'b0 && vsync_n === 1'b1) begin
      if (no_width) no_width = 1'b0;
      else check(cyc - fall_cyc == PW, "R5", cyc - fall_cyc, PW);
    end
    vs_prev = vsync_n;
  end

  task automatic expect_fall(input int c, input string req);
    exp_q.push_back(c);
    tag_q.push_back(req);
  endtask

  task automatic hold(input logic lvl, input int n);
    csync_n = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic eq_pulses(input int k);
    repeat (k) begin hold(1'b0, 23); hold(1'b1, 295); end
  endtask

  task automatic h_lines(input int k);
    repeat (k) begin hold(1'b0, 47); hold(1'b1, 589); end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic check_count(input int n, input string req);
    check(n_fall == n, req, n_fall, n);
  endtask

  int f1, cr, f2, ca;

  initial begin
    repeat (3) @(negedge clk);
    check(vsync_n === 1'b1, "R1", int'(vsync_n), 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(vsync_n === 1'b1, "R1", int'(vsync_n), 1);
    check_count(0, "R1");

    // R7: horizontal lines and equalizing pulses only
    cur_req = "R7";
    h_lines(12); eq_pulses(6); h_lines(3);
    check_count(0, "R7");
    check(vsync_n === 1'b1, "R7", int'(vsync_n), 1);

    // R3: field with serrations; later serrations fall inside lockout (R6)
    cur_req = "R3";
    eq_pulses(6);
    hold(1'b0, 271);
    expect_fall(cyc + 2, "R3");
    hold(1'b1, 47);
    cur_req = "R6";
    repeat (5) begin hold(1'b0, 271); hold(1'b1, 47); end
    eq_pulses(6); h_lines(4);
    check_count(1, "R6");
    hold(1'b1, 4500);

    // R4: field without serrations, input held low
    cur_req = "R4";
    eq_pulses(6);
    expect_fall(cyc + 1 + TMO, "R4");
    hold(1'b0, 1000);
    hold(1'b1, 4500);
    check_count(2, "R4");

    // R2: classification boundary
    cur_req = "R2";
    hold(1'b0, BROAD - 1);
    hold(1'b1, 600);
    check_count(2, "R2");
    hold(1'b0, BROAD);
    expect_fall(cyc + 2, "R2");
    hold(1'b1, 4500);
    check_count(3, "R2");

    // R6: lockout edges, one cycle early (rejected) and first accepted cycle
    cur_req = "R6";
    hold(1'b0, 200);
    f1 = cyc + 2;
    expect_fall(f1, "R6");
    hold(1'b1, 10);
    cr = f1 + PW + LOCK - 2;
    wait_until(cr - 200); csync_n = 1'b0;
    wait_until(cr);       csync_n = 1'b1;
    hold(1'b1, 600);
    check_count(4, "R6");
    hold(1'b0, 200);
    f2 = cyc + 2;
    expect_fall(f2, "R6");
    hold(1'b1, 10);
    ca = f2 + PW + LOCK - 1;
    wait_until(ca - 200); csync_n = 1'b0;
    wait_until(ca);       csync_n = 1'b1;
    expect_fall(ca + 2, "R6");
    hold(1'b1, 4500);
    check_count(6, "R6");

    // R8: reset during a pulse, then immediate re-fire
    cur_req = "R8";
    hold(1'b0, 200);
    expect_fall(cyc + 2, "R8");
    hold(1'b1, 50);
    no_width = 1'b1;
    rst_n = 1'b0;
    #1;
    check(vsync_n === 1'b1, "R8", int'(vsync_n), 1);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(vsync_n === 1'b1, "R8", int'(vsync_n), 1);
    hold(1'b0, 200);
    expect_fall(cyc + 2, "R8");
    hold(1'b1, 400);
    check_count(8, "R8");

    check(exp_q.size() == 0, (tag_q.size() != 0) ? tag_q[0] : "R3", exp_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 150000);
    summary();
    $finish;
  end

endmodule